// File: doc/BRIEF.md
# Transposable Subvector Element Sequencer

This block steps through a vector of VL elements. Each element is a group of SUBVL sub-elements (one to four, as in two-, three- and four-component vectors). The walk is a loop over a grid of VL rows by SUBVL columns. On each step the block gives a source linear index and a destination linear index. For grid position (element e, sub-element s) the linear index is e*SUBVL + s. Each side carries its own swap bit. When the bit is clear, that side walks rows in the outer loop and columns in the inner loop. When the bit is set, that side's two loops trade places, and the side visits the grid in transposed order. Both sides advance from one shared step count, so a single pass can read in one order and write in another.

A start pulse loads the whole setup in one go: VL, the SUBVL code, both swap bits and the per-element predicate. This works like a management command that writes the loop-state register, and it is not decoded per instruction. A predicate bit covers every sub-element of its element. A step whose source element or destination element is masked off never presents a valid index. The block skips such a step by itself, one cycle per step. An active step holds its indices until the consumer raises `advance`. After the final step has gone, `done` rises and stays high until the next start.

Top module: `xpose_seq`

## Requirements
- R1: After reset, `idx_valid` and `done` are low and the block sits idle until a start pulse.
- R2: On a side whose swap bit is clear, step k (counting from 0) visits element k / SUBVL and sub-element k % SUBVL. The index it outputs is element*SUBVL + sub-element.
- R3: On a side whose swap bit is set, step k visits element k % VL and sub-element k / VL. The index uses the same formula element*SUBVL + sub-element.
- R4: The source and destination swap bits act on their own sides only. All four combinations give the orders of R2 and R3, and both indices step on the same step count.
- R5: The 2-bit `subvl_code` input value n selects SUBVL = n+1, so a walk has VL*(n+1) steps.
- R6: Predicate bit e (bit 0 = element 0) covers every sub-element of element e. A step is active only if the predicate bits of both its source element and its destination element are 1. An inactive step keeps `idx_valid` low and is passed in exactly one cycle, whatever `advance` is.
- R7: While an active step is presented and `advance` is low, `idx_valid`, `src_idx` and `dst_idx` stay unchanged into the next cycle.
- R8: `done` rises in the cycle after the last step is passed (accepted or skipped). It stays high with `idx_valid` low until a start pulse.
- R9: A start with VL = 0 makes `done` high in the next cycle, with no valid step.
- R10: A start pulse during a walk is ignored. The setup inputs are captured only at an accepted start, so changing them mid-walk does not alter the walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Loads setup and begins a walk when not walking |
| vl_in | input | $clog2(MAX_VL+1) | Element count; values above MAX_VL are clamped |
| subvl_code | input | 2 | Sub-element count minus one |
| src_swap | input | 1 | Transpose the source walk |
| dst_swap | input | 1 | Transpose the destination walk |
| pred_mask | input | MAX_VL | Per-element predicate, bit e for element e |
| advance | input | 1 | Consumer accepts the presented step |
| src_idx | output | $clog2(MAX_VL*4) | Source linear index |
| dst_idx | output | $clog2(MAX_VL*4) | Destination linear index |
| idx_valid | output | 1 | Indices belong to an active step |
| done | output | 1 | Walk finished; waiting for start |

## Verification
The bench builds the block with the default MAX_VL of 16, so the predicate is 16 bits wide and the longest walk is 64 steps. That allows full-length walks with SUBVL = 4 and both sides transposed, and odd sizes such as VL = 5 or 7 where the transposed and plain orders differ clearly. It also covers the edge shapes VL = 1, VL = 0 and a fully masked predicate. A reference model computes each step's element and sub-element by division and remainder. The bench runs it against every cycle under steady and stalling `advance` patterns, including a start pulse and setup changes in the middle of a walk.

// File: rtl/xpose_pkg.sv
package xpose_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } walk_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // capture setup, zero counters
    logic stepAdv;  // move to the next grid position
  } walk_ctrl_t;
endpackage

// File: rtl/xpose_walk.sv
// One side of the walk: element / sub-element counters in a selectable nest order.
module xpose_walk #(
  parameter int MAX_VL = 16,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int EW   = $clog2(MAX_VL),
  localparam int IDXW = $clog2(MAX_VL * 4)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic            step,
  input  logic            swap,
  input  logic [VLW-1:0]  vlLat,
  input  logic [2:0]      subvlLat,
  output logic [EW-1:0]   elem,
  output logic [1:0]      sub,
  output logic [IDXW-1:0] idx
);
  logic subWrap;
  logic elemWrap;

  assign subWrap  = ({1'b0, sub} == (subvlLat - 3'd1));
  assign elemWrap = (VLW'(elem) == (vlLat - VLW'(1)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem <= '0;
      sub  <= '0;
    end else if (load) begin
      elem <= '0;
      sub  <= '0;
    end else if (step) begin
      if (!swap) begin
        if (subWrap) begin
          sub  <= '0;
          elem <= elem + EW'(1);
        end else begin
          sub <= sub + 2'd1;
        end
      end else begin
        if (elemWrap) begin
          elem <= '0;
          sub  <= sub + 2'd1;
        end else begin
          elem <= elem + EW'(1);
        end
      end
    end
  end

  assign idx = IDXW'(elem) * IDXW'(subvlLat) + IDXW'(sub);
endmodule

// File: rtl/xpose_dpath.sv
// Setup register, shared step counter and the two side walkers.
module xpose_dpath
  import xpose_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int EW   = $clog2(MAX_VL),
  localparam int IDXW = $clog2(MAX_VL * 4),
  localparam int PW   = VLW + 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walk_ctrl_t        ctrl,
  input  logic [VLW-1:0]    vlIn,
  input  logic [1:0]        subvlCode,
  input  logic              srcSwap,
  input  logic              dstSwap,
  input  logic [MAX_VL-1:0] predMask,
  output logic              vlZero,
  output logic              lastStep,
  output logic              active,
  output logic [IDXW-1:0]   srcIdx,
  output logic [IDXW-1:0]   dstIdx
);
  logic [VLW-1:0]    vlClamp;
  logic [VLW-1:0]    vlLat;
  logic [2:0]        subvlLat;
  logic [1:0]        swapLat;
  logic [MAX_VL-1:0] maskLat;
  logic [IDXW-1:0]   stepCnt;
  logic [IDXW-1:0]   lastCnt;
  logic [PW-1:0]     total;

  logic [EW-1:0]   elemArr [2];
  logic [1:0]      subArr  [2];
  logic [IDXW-1:0] idxArr  [2];

  assign vlClamp = (vlIn > VLW'(MAX_VL)) ? VLW'(MAX_VL) : vlIn;
  assign vlZero  = (vlIn == '0);
  assign total   = PW'(vlClamp) * PW'({1'b0, subvlCode} + 3'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vlLat    <= '0;
      subvlLat <= 3'd1;
      swapLat  <= '0;
      maskLat  <= '0;
      lastCnt  <= '0;
      stepCnt  <= '0;
    end else if (ctrl.load) begin
      vlLat    <= vlClamp;
      subvlLat <= {1'b0, subvlCode} + 3'd1;
      swapLat  <= {dstSwap, srcSwap};
      maskLat  <= predMask;
      lastCnt  <= IDXW'(total - PW'(1));
      stepCnt  <= '0;
    end else if (ctrl.stepAdv) begin
      stepCnt <= stepCnt + IDXW'(1);
    end
  end

  // side 0 = source, side 1 = destination
  for (genvar s = 0; s < 2; s++) begin : g_side
    xpose_walk #(.MAX_VL(MAX_VL)) u_walk (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ctrl.load),
      .step     (ctrl.stepAdv),
      .swap     (swapLat[s]),
      .vlLat    (vlLat),
      .subvlLat (subvlLat),
      .elem     (elemArr[s]),
      .sub      (subArr[s]),
      .idx      (idxArr[s])
    );
  end

  assign lastStep = (stepCnt == lastCnt);
  assign active   = maskLat[elemArr[0]] & maskLat[elemArr[1]];
  assign srcIdx   = idxArr[0];
  assign dstIdx   = idxArr[1];
endmodule

// File: rtl/xpose_ctrl.sv
// Walk state machine: start, skip of masked steps, handshake and finish.
module xpose_ctrl
  import xpose_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       vlZero,
  input  logic       lastStep,
  input  logic       active,
  input  logic       advance,
  output walk_ctrl_t ctrl,
  output logic       idxValid,
  output logic       done
);
  walk_state_e state;
  walk_state_e stateNext;

  always_comb begin
    stateNext    = state;
    ctrl.load    = 1'b0;
    ctrl.stepAdv = 1'b0;
    idxValid     = 1'b0;
    unique case (state)
      ST_IDLE, ST_FIN: begin
        if (start) begin
          ctrl.load = 1'b1;
          stateNext = vlZero ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        idxValid     = active;
        ctrl.stepAdv = !active || advance;
        if (ctrl.stepAdv && lastStep) stateNext = ST_FIN;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  assign done = (state == ST_FIN);
endmodule

// File: rtl/xpose_seq.sv
// Top: thin wrapper joining control and datapath.
module xpose_seq
  import xpose_pkg::*;
#(
  parameter int MAX_VL = 16,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = $clog2(MAX_VL * 4)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VLW-1:0]    vl_in,
  input  logic [1:0]        subvl_code,
  input  logic              src_swap,
  input  logic              dst_swap,
  input  logic [MAX_VL-1:0] pred_mask,
  input  logic              advance,
  output logic [IDXW-1:0]   src_idx,
  output logic [IDXW-1:0]   dst_idx,
  output logic              idx_valid,
  output logic              done
);
  walk_ctrl_t ctrl;
  logic vlZero;
  logic lastStep;
  logic active;

  xpose_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .vlZero   (vlZero),
    .lastStep (lastStep),
    .active   (active),
    .advance  (advance),
    .ctrl     (ctrl),
    .idxValid (idx_valid),
    .done     (done)
  );

  xpose_dpath #(.MAX_VL(MAX_VL)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl      (ctrl),
    .vlIn      (vl_in),
    .subvlCode (subvl_code),
    .srcSwap   (src_swap),
    .dstSwap   (dst_swap),
    .predMask  (pred_mask),
    .vlZero    (vlZero),
    .lastStep  (lastStep),
    .active    (active),
    .srcIdx    (src_idx),
    .dstIdx    (dst_idx)
  );
endmodule

// File: rtl/xpose_seq_chk.sv
module xpose_seq_chk #(
  parameter int MAX_VL = 16,
  localparam int VLW  = $clog2(MAX_VL + 1),
  localparam int IDXW = $clog2(MAX_VL * 4)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [VLW-1:0]  vl_in,
  input logic            advance,
  input logic [IDXW-1:0] src_idx,
  input logic [IDXW-1:0] dst_idx,
  input logic            idx_valid,
  input logic            done
);
  // R8
  valid_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(idx_valid && done));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && !advance) |=> (idx_valid && $stable(src_idx) && $stable(dst_idx)));

  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  // R9
  zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start && vl_in == '0) |=> (done && !idx_valid));

  // R10
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idx_valid && !advance && start) |=> (idx_valid && !done && $stable(src_idx)));
endmodule

bind xpose_seq xpose_seq_chk #(.MAX_VL(MAX_VL)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .vl_in     (vl_in),
  .advance   (advance),
  .src_idx   (src_idx),
  .dst_idx   (dst_idx),
  .idx_valid (idx_valid),
  .done      (done)
);

// File: tb/xpose_seq_tb.sv
`timescale 1ns/1ps
module xpose_seq_tb;
  localparam int MAX_VL = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  vl_in = '0;
  logic [1:0]  subvl_code = '0;
  logic        src_swap = 1'b0;
  logic        dst_swap = 1'b0;
  logic [15:0] pred_mask = '0;
  logic        advance = 1'b0;
  logic [5:0]  src_idx;
  logic [5:0]  dst_idx;
  logic        idx_valid;
  logic        done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  // reference model state
  int mState = 0;  // 0 idle, 1 walking, 2 finished
  int mK = 0;
  int mVl = 0;
  int mSv = 1;
  bit mSs = 0;
  bit mDs = 0;
  logic [15:0] mMask = '0;
  int handCnt = 0;

  always #4 clk = ~clk;

  xpose_seq #(.MAX_VL(MAX_VL)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_in(vl_in),
    .subvl_code(subvl_code), .src_swap(src_swap), .dst_swap(dst_swap),
    .pred_mask(pred_mask), .advance(advance), .src_idx(src_idx),
    .dst_idx(dst_idx), .idx_valid(idx_valid), .done(done)
  );

  function automatic int elemOf(int k, bit sw);
    return sw ? (k % mVl) : (k / mSv);
  endfunction
  function automatic int subOf(int k, bit sw);
    return sw ? (k / mVl) : (k % mSv);
  endfunction
  function automatic bit modelActive();
    return mMask[elemOf(mK, mSs)] && mMask[elemOf(mK, mDs)];
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // model update
  always @(posedge clk) begin
    cycles++;
    if (rst_n) begin
      if (mState != 1 && start) begin
        mVl = int'(vl_in);
        mSv = int'(subvl_code) + 1;
        mSs = src_swap;
        mDs = dst_swap;
        mMask = pred_mask;
        mK = 0;
        handCnt = 0;
        mState = (mVl == 0) ? 2 : 1;
      end else if (mState == 1) begin
        bit act;
        act = modelActive();
        if (act && advance) handCnt++;
        if (!act || advance) begin
          if (mK == mVl * mSv - 1) mState = 2;
          else mK++;
        end
      end
    end
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  // comparison away from the clock edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit expValid;
      expValid = (mState == 1) && modelActive();
      check("R6 idx_valid", int'(idx_valid), int'(expValid));
      check("R8 done", int'(done), int'(mState == 2));
      if (expValid && idx_valid) begin
        int es, ss, ed, sd;
        es = elemOf(mK, mSs); ss = subOf(mK, mSs);
        ed = elemOf(mK, mDs); sd = subOf(mK, mDs);
        check(mSs ? "R3/R4/R5/R7 src_idx" : "R2/R4/R5/R7 src_idx",
              int'(src_idx), es * mSv + ss);
        check(mDs ? "R3/R4/R5/R7 dst_idx" : "R2/R4/R5/R7 dst_idx",
              int'(dst_idx), ed * mSv + sd);
      end
    end
  end

  function automatic int expectHand(int vl, int sv, bit ss, bit ds, logic [15:0] m);
    int n = 0;
    for (int k = 0; k < vl * sv; k++) begin
      int e1 = ss ? k % vl : k / sv;
      int e2 = ds ? k % vl : k / sv;
      if (m[e1] && m[e2]) n++;
    end
    return n;
  endfunction

  task automatic runWalk(input int vl, input int code, input bit ss, input bit ds,
                         input logic [15:0] m, input int pat, input bit midStart);
    int n = 0;
    @(posedge clk); #2;
    vl_in = 5'(vl); subvl_code = 2'(code); src_swap = ss; dst_swap = ds;
    pred_mask = m; start = 1'b1; advance = 1'b0;
    @(posedge clk); #2;
    start = 1'b0;
    while (mState != 2 && n < 2000) begin
      advance = (pat == 0) ? 1'b1 : ((n % 3) != 0);
      if (midStart && (n == 3 || n == 4)) begin
        start = 1'b1; vl_in = 5'd2; src_swap = ~ss; dst_swap = ~ds;
        subvl_code = 2'd0; pred_mask = '0;
      end else begin
        start = 1'b0;
      end
      @(posedge clk); #2;
      n++;
    end
    start = 1'b0; advance = 1'b0;
    @(negedge clk);
    // R8: finished and holding
    check("R8 done after walk", int'(done), 1);
    check("R8 no valid when done", int'(idx_valid), 0);
    // R10: accepted count equals the walk captured at the first start
    check("R10 handoff count", handCnt, expectHand(vl, code + 1, ss, ds, m));
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(posedge clk);
    #2;
    check("R1 idx_valid at reset", int'(idx_valid), 0);
    check("R1 done at reset", int'(done), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 idle without start", int'(idx_valid), 0);
    check("R1 done idle", int'(done), 0);

    runWalk(5, 2, 0, 0, 16'hFFFF, 0, 0);
    runWalk(5, 2, 1, 0, 16'hFFFF, 1, 0);
    runWalk(5, 2, 0, 1, 16'hFFFF, 1, 0);
    runWalk(5, 2, 1, 1, 16'hFFFF, 0, 0);
    runWalk(7, 3, 1, 0, 16'b0000_0000_0101_1011, 1, 0);
    runWalk(7, 1, 0, 1, 16'b0000_0000_0110_1101, 0, 0);
    runWalk(1, 0, 1, 1, 16'h0001, 1, 0);
    runWalk(16, 3, 1, 1, 16'hAAAA, 1, 0);
    runWalk(16, 3, 0, 1, 16'hF0F7, 0, 0);
    runWalk(3, 2, 0, 0, 16'h0000, 0, 0);
    // R9 zero length
    runWalk(0, 2, 1, 0, 16'hFFFF, 0, 0);
    check("R9 no handoff for VL 0", handCnt, 0);
    // R10 start and setup changes mid-walk
    runWalk(4, 1, 0, 1, 16'hFFFF, 1, 1);
    runWalk(6, 2, 1, 0, 16'h003D, 1, 1);

    finishRun();
  end
endmodule